// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Transfer Engine

This block is one DMA channel. It copies values from a source address to a destination address over a simple request/acknowledge memory port. Each element is 8, 16 or 32 bits wide. The channel first reads the element, then writes it once the read data is back. Software first loads the start addresses. It then sets the per-transfer options: the element size, whether each address steps forward or stays fixed, the element count, single-element or whole-block mode, circular reload, and whether an interrupt is raised.

A transfer can be started in three ways: a software start strobe, a hardware request line from a peripheral, or a link request from another channel. The channel stays busy until its last write is acknowledged. It then pulses `done` and can latch a pending interrupt that software clears. In normal mode the working addresses stay where the last element left them, so the next start carries on from there. In circular mode the working addresses return to the loaded start addresses at the end of every block.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `busy`, `done`, `irq` and `mem_req` are all low.
- R2: While idle, a high level on any of `sw_start`, `hw_req` or `chain_req` at a clock edge starts the channel. `busy` and a read request follow in the next cycle.
- R3: Each element is a read (`mem_we`=0) at the working source address, held until `mem_ack`. In the cycle after the read acknowledge, a write (`mem_we`=1) to the working destination address is presented and held until `mem_ack`. No write is presented before its read is acknowledged.
- R4: `cfg_size` code 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. `mem_size` carries the effective code (0, 1 or 2). `mem_wdata` is the read data with every bit above the element width forced to zero.
- R5: After each written element, an address whose increment enable is set advances by 1, 2 or 4 bytes to match the element size. An address whose enable is clear stays put. Source and destination are handled independently.
- R6: In block mode (`cfg_single`=0), one start moves `cfg_count` elements, and a count of 0 moves one element. In single mode (`cfg_single`=1), one start moves exactly one element.
- R7: With `cfg_circular`=0, the next start continues from the addresses where the previous transfer stopped. With `cfg_circular`=1, both working addresses return to the loaded start addresses when the transfer ends.
- R8: `done` is high for exactly one cycle: the cycle after the final write acknowledge. `busy` falls in that same cycle.
- R9: A start on any source while the channel is busy is ignored and does not change the number of elements moved.
- R10: If `cfg_irq_en` was set at the start, `irq` rises together with `done` and stays high until a cycle with `irq_clr` high. If completion and `irq_clr` fall in the same cycle, `irq` ends up set.
- R11: `desc_load` while idle sets both the start and working addresses from `cfg_src_addr` and `cfg_dst_addr`. `desc_load` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_load | input | 1 | Load start and working addresses (idle only) |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_inc | input | 1 | Source address steps after each element |
| cfg_dst_inc | input | 1 | Destination address steps after each element |
| cfg_size | input | 2 | Element size code |
| cfg_count | input | CW | Elements per block |
| cfg_single | input | 1 | One element per start |
| cfg_circular | input | 1 | Reload start addresses at the end |
| cfg_irq_en | input | 1 | Raise interrupt on completion |
| sw_start | input | 1 | Software start |
| hw_req | input | 1 | Peripheral start request |
| chain_req | input | 1 | Start request from another channel |
| irq_clr | input | 1 | Clear pending interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access byte address |
| mem_size | output | 2 | Effective size code of the access |
| mem_wdata | output | 32 | Write data, zero-extended |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data, value in low bits |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Pending completion interrupt |

## Verification
Two events can land on the same clock edge. The completion that sets the interrupt can coincide with a software clear of it. A start request can also arrive on the very edge where the channel returns to idle, or while it is still busy. The bench holds `irq_clr` high across a whole transfer, so the set and the clear meet at the final acknowledge. There it expects `irq` high in the `done` cycle and low one cycle later. A behavioural model, fed the same random acknowledge stalls, predicts every output on every clock, so a start pulse or a `desc_load` that lands mid-transfer is judged by the addresses and the write count that follow it.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } dma_state_e;

   localparam int unsigned DATA_W = 32;

   // size code 3 is treated as a 32-bit element
   function automatic logic [1:0] eff_size(input logic [1:0] code);
      return (code == 2'd3) ? 2'd2 : code;
   endfunction

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      return 3'd1 << eff_size(code);
   endfunction

   function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] code);
      logic [DATA_W-1:0] m;
      case (eff_size(code))
         2'd0:    m = {{(DATA_W-8){1'b0}}, 8'hFF};
         2'd1:    m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
         default: m = {DATA_W{1'b1}};
      endcase
      return m;
   endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_xfer_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base_in,
   input  logic          step,
   input  logic          reload,
   input  logic          inc_en,
   input  logic [1:0]    size,
   output logic [AW-1:0] cur
);

   logic [AW-1:0] base_q;
   logic [AW-1:0] cur_q;
   logic [AW-1:0] stride;

   assign stride = AW'(size_bytes(size));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         base_q <= base_in;
         cur_q  <= base_in;
      end else if (reload) begin
         cur_q  <= base_q;
      end else if (step && inc_en) begin
         cur_q  <= cur_q + stride;
      end
   end

   assign cur = cur_q;

endmodule

// File: rtl/dma_blk_ctr.sv
module dma_blk_ctr #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          last
);

   logic [CW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= load_val;
      end else if (dec && !last) begin
         rem_q <= rem_q - CW'(1);
      end
   end

   assign last = (rem_q == CW'(1));

endmodule

// File: rtl/dma_ctl_fsm.sv
module dma_ctl_fsm
   import dma_xfer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic       ack,
   input  logic       last,
   output dma_state_e state,
   output logic       done
);

   dma_state_e state_q, state_d;
   logic       done_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (accept) state_d = ST_READ;
         ST_READ:  if (ack)    state_d = ST_WRITE;
         ST_WRITE: if (ack)    state_d = last ? ST_IDLE : ST_READ;
         default:              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_WRITE) && ack && last;
      end
   end

   assign state = state_q;
   assign done  = done_q;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_xfer_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          desc_load,
   input  logic [AW-1:0] cfg_src_addr,
   input  logic [AW-1:0] cfg_dst_addr,
   input  logic          cfg_src_inc,
   input  logic          cfg_dst_inc,
   input  logic [1:0]    cfg_size,
   input  logic [CW-1:0] cfg_count,
   input  logic          cfg_single,
   input  logic          cfg_circular,
   input  logic          cfg_irq_en,
   input  logic          sw_start,
   input  logic          hw_req,
   input  logic          chain_req,
   input  logic          irq_clr,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          busy,
   output logic          done,
   output logic          irq
);

   localparam int unsigned NPORT = 2;   // 0 = source, 1 = destination

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("dma_xfer_engine: AW must be within 8..64");
   end
   if (CW < 1 || CW > 32) begin : g_bad_cw
      $error("dma_xfer_engine: CW must be within 1..32");
   end

   dma_state_e    state;
   logic          idle;
   logic          accept;
   logic          rd_fire;
   logic          wr_fire;
   logic          last;
   logic          fin;
   logic [CW-1:0] blk_len;

   logic [1:0]    size_q;
   logic          circ_q;
   logic          irq_en_q;
   logic [NPORT-1:0] inc_q;
   logic [31:0]   data_q;
   logic          irq_q;

   logic [AW-1:0] base_arr [NPORT];
   logic [AW-1:0] cur_arr  [NPORT];
   logic [NPORT-1:0] inc_cfg;

   assign idle    = (state == ST_IDLE);
   assign accept  = idle && (sw_start || hw_req || chain_req);
   assign rd_fire = (state == ST_READ)  && mem_ack;
   assign wr_fire = (state == ST_WRITE) && mem_ack;
   assign fin     = wr_fire && last;
   assign blk_len = (cfg_single || cfg_count == '0) ? CW'(1) : cfg_count;

   assign base_arr[0] = cfg_src_addr;
   assign base_arr[1] = cfg_dst_addr;
   assign inc_cfg     = {cfg_dst_inc, cfg_src_inc};

   // per-transfer options, captured when a start is taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q   <= 2'd0;
         circ_q   <= 1'b0;
         irq_en_q <= 1'b0;
         inc_q    <= '0;
      end else if (accept) begin
         size_q   <= eff_size(cfg_size);
         circ_q   <= cfg_circular;
         irq_en_q <= cfg_irq_en;
         inc_q    <= inc_cfg;
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      dma_addr_gen #(.AW(AW)) u_addr (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (desc_load && idle),
         .base_in (base_arr[p]),
         .step    (wr_fire),
         .reload  (fin && circ_q),
         .inc_en  (inc_q[p]),
         .size    (size_q),
         .cur     (cur_arr[p])
      );
   end

   dma_blk_ctr #(.CW(CW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (blk_len),
      .dec      (wr_fire),
      .last     (last)
   );

   dma_ctl_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .ack    (mem_ack),
      .last   (last),
      .state  (state),
      .done   (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (rd_fire) begin
         data_q <= mem_rdata & size_mask(size_q);
      end
   end

   // completion sets the pending bit ahead of a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (fin && irq_en_q) begin
         irq_q <= 1'b1;
      end else if (irq_clr) begin
         irq_q <= 1'b0;
      end
   end

   assign mem_req   = !idle;
   assign mem_we    = (state == ST_WRITE);
   assign mem_addr  = mem_we ? cur_arr[1] : cur_arr[0];
   assign mem_size  = size_q;
   assign mem_wdata = data_q;
   assign busy      = !idle;
   assign irq       = irq_q;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          irq,
   input logic          irq_clr,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [1:0]    mem_size,
   input logic [31:0]   mem_wdata
);

   // R3
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

   // R3
   hold_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R2
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R4
   size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_size != 2'd3));

   // R4
   byte_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_size == 2'd0) |-> (mem_wdata[31:8] == 24'd0));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_req && mem_we && mem_ack));

   // R10
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> done);

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .irq       (irq),
   .irq_clr   (irq_clr),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_size  (mem_size),
   .mem_wdata (mem_wdata)
);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          desc_load, cfg_src_inc, cfg_dst_inc, cfg_single, cfg_circular, cfg_irq_en;
   logic [AW-1:0] cfg_src_addr, cfg_dst_addr;
   logic [1:0]    cfg_size;
   logic [CW-1:0] cfg_count;
   logic          sw_start, hw_req, chain_req, irq_clr;
   logic          mem_req, mem_we, mem_ack, busy, done, irq;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_size;
   logic [31:0]   mem_wdata, mem_rdata;
   logic [15:0]   lfsr = 16'hACE1;
   logic          stall_n;

   int checks = 0;
   int errs   = 0;
   int cyc    = 0;
   int wr_cnt = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] rd_val(input logic [31:0] a);
      return {a[7:0] ^ 8'h3C, a[15:8] + 8'h11, ~a[7:0], a[7:0] + 8'h5A};
   endfunction

   function automatic logic [31:0] mask_of(input logic [1:0] s);
      return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   assign stall_n   = lfsr[0] | lfsr[3];
   assign mem_ack   = mem_req & stall_n;
   assign mem_rdata = rd_val(mem_addr);

   always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

   dma_xfer_engine #(.AW(AW), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .desc_load(desc_load),
      .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
      .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_size(cfg_size),
      .cfg_count(cfg_count), .cfg_single(cfg_single), .cfg_circular(cfg_circular),
      .cfg_irq_en(cfg_irq_en), .sw_start(sw_start), .hw_req(hw_req),
      .chain_req(chain_req), .irq_clr(irq_clr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   endtask

   // behavioural reference model
   int          m_st;    // 0 idle, 1 read, 2 write
   int          m_rem;
   logic [31:0] m_src, m_dst, m_bsrc, m_bdst, m_data;
   logic [1:0]  m_sz;
   bit          m_sinc, m_dinc, m_circ, m_ien, m_done, m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_rem = 0; m_src = 0; m_dst = 0; m_bsrc = 0; m_bdst = 0; m_data = 0;
         m_sz = 0; m_sinc = 0; m_dinc = 0; m_circ = 0; m_ien = 0; m_done = 0; m_irq = 0;
      end else begin
         bit ack;
         bit dn;
         ack = (m_st != 0) && stall_n;
         dn  = 0;
         if (m_st == 0) begin
            if (desc_load) begin
               m_bsrc = cfg_src_addr; m_src = cfg_src_addr;
               m_bdst = cfg_dst_addr; m_dst = cfg_dst_addr;
            end
            if (sw_start || hw_req || chain_req) begin
               m_sz   = (cfg_size == 2'd3) ? 2'd2 : cfg_size;
               m_sinc = cfg_src_inc; m_dinc = cfg_dst_inc;
               m_circ = cfg_circular; m_ien = cfg_irq_en;
               m_rem  = (cfg_single || cfg_count == 0) ? 1 : int'(cfg_count);
               m_st   = 1;
            end
         end else if (m_st == 1) begin
            if (ack) begin
               m_data = rd_val(m_src) & mask_of(m_sz);
               m_st = 2;
            end
         end else if (ack) begin
            if (m_sinc) m_src = m_src + (32'd1 << m_sz);
            if (m_dinc) m_dst = m_dst + (32'd1 << m_sz);
            if (m_rem == 1) begin
               dn = 1;
               if (m_circ) begin m_src = m_bsrc; m_dst = m_bdst; end
               m_st = 0;
            end else begin
               m_rem--;
               m_st = 1;
            end
         end
         if (dn && m_ien) m_irq = 1;
         else if (irq_clr) m_irq = 0;
         m_done = dn;
      end
   end

   // per-clock comparison, away from the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !finished) begin
         chk(busy == (m_st != 0), "R2 busy", 32'(busy), 32'(m_st != 0));
         chk(mem_req == (m_st != 0), "R3 mem_req", 32'(mem_req), 32'(m_st != 0));
         if (m_st != 0) begin
            chk(mem_we == (m_st == 2), "R3 mem_we", 32'(mem_we), 32'(m_st == 2));
            chk(mem_addr == ((m_st == 2) ? m_dst : m_src), "R5 mem_addr", mem_addr,
                (m_st == 2) ? m_dst : m_src);
            chk(mem_size == m_sz, "R4 mem_size", 32'(mem_size), 32'(m_sz));
         end
         if (m_st == 2) chk(mem_wdata == m_data, "R4 mem_wdata", mem_wdata, m_data);
         chk(done == m_done, "R8 done", 32'(done), 32'(m_done));
         chk(irq == m_irq, "R10 irq", 32'(irq), 32'(m_irq));
      end
   end

   always @(posedge clk) begin
      if (rst_n && mem_req && mem_we && mem_ack) wr_cnt++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         checks++;
         errs++;
         $display("FAIL watchdog: run did not complete");
         summary();
      end
   end

   task automatic start_blk(input int sel, input logic [31:0] exp_rd, input string tag);
      @(negedge clk);
      case (sel)
         0:       sw_start  = 1'b1;
         1:       hw_req    = 1'b1;
         default: chain_req = 1'b1;
      endcase
      @(negedge clk);
      sw_start = 1'b0; hw_req = 1'b0; chain_req = 1'b0;
      chk(mem_req && !mem_we && mem_addr == exp_rd, tag, mem_addr, exp_rd);
   endtask

   task automatic wait_idle();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (busy && n < 5000);
   endtask

   task automatic set_cfg(input logic [1:0] sz, input bit si, input bit di, input int cnt,
                          input bit single, input bit circ, input bit ien);
      cfg_size = sz; cfg_src_inc = si; cfg_dst_inc = di; cfg_count = CW'(cnt);
      cfg_single = single; cfg_circular = circ; cfg_irq_en = ien;
   endtask

   initial begin
      int w0;
      rst_n = 1'b0; desc_load = 0; sw_start = 0; hw_req = 0; chain_req = 0; irq_clr = 0;
      cfg_src_addr = 32'h1000; cfg_dst_addr = 32'h2000;
      set_cfg(2'd2, 1, 1, 4, 0, 0, 0);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !irq && !mem_req, "R1 reset outputs",
          {28'd0, busy, done, irq, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      desc_load = 1'b1;
      @(negedge clk);
      desc_load = 1'b0;

      // word block of 4, both addresses stepping, no interrupt
      w0 = wr_cnt;
      start_blk(0, 32'h1000, "R2 software start first read");
      wait_idle();
      chk(wr_cnt - w0 == 4, "R6 block of four", 32'(wr_cnt - w0), 32'd4);
      chk(irq == 1'b0, "R10 disabled interrupt stays low", 32'(irq), 32'd0);

      // byte block of 3, destination fixed; restarts and a load while busy
      set_cfg(2'd0, 1, 0, 3, 0, 0, 1);
      w0 = wr_cnt;
      start_blk(1, 32'h1010, "R7 continue after non-circular block");
      chain_req = 1'b1; desc_load = 1'b1; cfg_src_addr = 32'h5000;
      @(negedge clk);
      chain_req = 1'b0; desc_load = 1'b0;
      wait_idle();
      chk(wr_cnt - w0 == 3, "R9 start while busy ignored", 32'(wr_cnt - w0), 32'd3);

      // halfword circular block of 2, twice
      set_cfg(2'd1, 1, 1, 2, 0, 1, 1);
      w0 = wr_cnt;
      start_blk(2, 32'h1013, "R11 load while busy ignored");
      wait_idle();
      start_blk(0, 32'h1000, "R7 circular reload to start");
      wait_idle();
      chk(wr_cnt - w0 == 4, "R6 two circular blocks", 32'(wr_cnt - w0), 32'd4);

      // new addresses while idle, single-element mode with size code 3
      cfg_src_addr = 32'h3000; cfg_dst_addr = 32'h4000;
      @(negedge clk);
      desc_load = 1'b1;
      @(negedge clk);
      desc_load = 1'b0;
      set_cfg(2'd3, 1, 1, 7, 1, 0, 1);
      w0 = wr_cnt;
      start_blk(0, 32'h3000, "R11 load while idle");
      wait_idle();
      chk(wr_cnt - w0 == 1, "R6 single mode one element", 32'(wr_cnt - w0), 32'd1);

      // zero count in block mode
      set_cfg(2'd2, 1, 1, 0, 0, 0, 1);
      w0 = wr_cnt;
      start_blk(1, 32'h3004, "R5 word step of four");
      wait_idle();
      chk(wr_cnt - w0 == 1, "R6 zero count one element", 32'(wr_cnt - w0), 32'd1);
      repeat (3) @(negedge clk);
      chk(irq == 1'b1, "R10 pending held", 32'(irq), 32'd1);

      // clear held across a transfer: completion and clear coincide
      set_cfg(2'd1, 0, 1, 2, 0, 0, 1);
      irq_clr = 1'b1;
      start_blk(2, 32'h3008, "R2 link start first read");
      wait_idle();
      chk(done == 1'b1, "R8 done with busy fall", 32'(done), 32'd1);
      chk(irq == 1'b1, "R10 set wins over clear", 32'(irq), 32'd1);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", 32'(done), 32'd0);
      chk(irq == 1'b0, "R10 cleared afterwards", 32'(irq), 32'd0);
      irq_clr = 1'b0;
      repeat (4) @(negedge clk);
      summary();
   end

endmodule